// File: doc/BRIEF.md
# Modulated Infrared Transmit Waveform Generator

This block builds the transmit waveform for an infrared remote-control link. A carrier generator makes a square wave whose high and low phases last a programmed number of clock cycles. A modulator opens and closes a gate over that carrier: it opens for a mark interval and closes for a space interval, and the pair repeats. The gate can pass the carrier through. It can also drive the output level directly. A third option times the intervals in carrier periods and switches between two carrier settings on every modulation period, which gives frequency-shift keying.

The mark interval is timed by a down counter one bit wider than the mark value. The counter is loaded with a clear top bit. It goes negative when it underflows, and that closes the gate. The space interval is then timed without a second counter: the bitwise inverse of the same negative count is compared with the held space value. A match reloads both values and reopens the gate. A space value of zero therefore matches at the moment of underflow, and back-to-back bursts follow with no gap.

Software writes every setting through a small write port. New mark and space values wait in buffer registers until the next reload.

Top module: `cmt_modulated_tx`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at `wr_addr` on the clock edge. The address map is: 0 high count of setting A, 1 low count of A, 2 high count of B, 3 low count of B, 4 mark buffer, 5 space buffer, 6 control. Control bit 0 is the enable. Control bits 2:1 select the mode: 00 time, 01 baseband, 10 frequency-shift, 11 behaves as time.
- R2: The carrier stays high for H clock cycles and low for L clock cycles. A count of 0 acts as 1. The carrier restarts in its high phase when the modulator starts.
- R3: After a load, the gate stays open for M+1 modulator ticks, where M is the mark value. Clock cycles without a tick do not advance the counter. In time and baseband modes a tick is a high `mod_tick` at a clock edge.
- R4: After the gate closes, it stays closed for S ticks, where S is the space value. It then reopens with a fresh load. When S is 0, no closed interval occurs.
- R5: In time mode, and in the reserved mode 11, `tx_out` is the carrier ANDed with the gate.
- R6: In baseband mode, `tx_out` is the gate level.
- R7: In frequency-shift mode the tick is one completed carrier period and `mod_tick` is ignored. `tx_out` is the gated carrier. The carrier uses setting A in the first modulation period after enabling, then alternates between B and A. A switch happens only at a carrier period boundary.
- R8: `cycle_end` is high for exactly the first clock cycle of each reloaded mark interval, and for no other cycle.
- R9: The mark and space values are taken from their buffers at the start and at each reload. A buffer write in the middle of a period takes effect only at the next reload.
- R10: When the enable is cleared, `tx_out` and `cycle_end` go low in the very next cycle and stay low. The modulator state clears, and the setting selection returns to A. After the enable is set, there is one load cycle with the output low, and then the pattern restarts from the beginning.
- R11: After reset all registers are zero and `tx_out` and `cycle_end` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | MARK_W (16) | Write data |
| mod_tick | input | 1 | Modulator tick for time and baseband modes |
| tx_out | output | 1 | Modulated transmit waveform |
| cycle_end | output | 1 | Pulse in the first cycle of each reloaded mark |

## Verification
A control write lands at clock edge E0. The cycle after E0 is the load cycle, in which the output must be low. The pattern begins in the cycle after edge E1, so the bench counts that cycle as pattern cycle zero. From then on, a tick that the bench drives before an edge moves the gate in the cycle right after that edge. In frequency-shift mode the carrier period that ends at an edge plays the same role. `cycle_end` comes from a register, so it is due in the same cycle as the reopened gate. `tx_out` drops in the cycle right after the write that clears the enable. The bench drives inputs at the falling edge and samples one nanosecond after each rising edge. It advances its arithmetic model of carrier phase, period position and setting selection once per edge, so every comparison lines up with those cycles.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;

    localparam int ADDR_W    = 3;
    localparam int NUM_PAIRS = 2;

    localparam logic [ADDR_W-1:0] ADDR_MARK  = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_SPACE = 3'd5;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd6;

    typedef enum logic [1:0] {
        MODE_TIME = 2'b00,
        MODE_BASE = 2'b01,
        MODE_FSK  = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    // control register: bits [2:1] mode, bit [0] enable
    typedef struct packed {
        mode_e mode;
        logic  en;
    } ctrl_t;

    function automatic logic mode_is_fsk(ctrl_t c);
        return c.mode == MODE_FSK;
    endfunction

    function automatic logic mode_is_base(ctrl_t c);
        return c.mode == MODE_BASE;
    endfunction

endpackage

// File: rtl/cmt_regs.sv
`timescale 1ns/1ps
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int MARK_W = 16,
    parameter int CAR_W  = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [MARK_W-1:0]                   wr_data,
    output logic [NUM_PAIRS-1:0][CAR_W-1:0]     hi_cnt,
    output logic [NUM_PAIRS-1:0][CAR_W-1:0]     lo_cnt,
    output logic [MARK_W-1:0]                   mark_buf,
    output logic [MARK_W-1:0]                   space_buf,
    output ctrl_t                               ctrl
);

    // carrier count pairs: pair k high at address 2k, low at 2k+1
    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        localparam logic [ADDR_W-1:0] ADDR_HI = ADDR_W'(2 * k);
        localparam logic [ADDR_W-1:0] ADDR_LO = ADDR_W'(2 * k + 1);
        logic [CAR_W-1:0] hi_q, lo_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                hi_q <= '0;
                lo_q <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADDR_HI) hi_q <= wr_data[CAR_W-1:0];
                if (wr_addr == ADDR_LO) lo_q <= wr_data[CAR_W-1:0];
            end
        end

        assign hi_cnt[k] = hi_q;
        assign lo_cnt[k] = lo_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mark_buf  <= '0;
            space_buf <= '0;
            ctrl      <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_MARK:  mark_buf  <= wr_data;
                ADDR_SPACE: space_buf <= wr_data;
                ADDR_CTRL:  ctrl      <= ctrl_t'(wr_data[2:0]);
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/cmt_carrier.sv
`timescale 1ns/1ps
module cmt_carrier
    import cmt_pkg::*;
#(
    parameter int CAR_W = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            run,
    input  logic                            sel,
    input  logic [NUM_PAIRS-1:0][CAR_W-1:0] hi_cnt,
    input  logic [NUM_PAIRS-1:0][CAR_W-1:0] lo_cnt,
    output logic                            carrier,
    output logic                            period_end
);

    logic [CAR_W-1:0] cnt_q;
    logic             phase_hi_q;
    logic [CAR_W-1:0] hi_sel, lo_sel, last_hi, last_lo;
    logic             at_end;

    always_comb begin
        hi_sel  = hi_cnt[sel];
        lo_sel  = lo_cnt[sel];
        // a count of zero behaves as one
        last_hi = (hi_sel == '0) ? '0 : hi_sel - CAR_W'(1);
        last_lo = (lo_sel == '0) ? '0 : lo_sel - CAR_W'(1);
        at_end  = cnt_q >= (phase_hi_q ? last_hi : last_lo);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q      <= '0;
            phase_hi_q <= 1'b1;
        end else if (at_end) begin
            cnt_q      <= '0;
            phase_hi_q <= ~phase_hi_q;
        end else begin
            cnt_q      <= cnt_q + CAR_W'(1);
        end
    end

    assign carrier    = phase_hi_q;
    assign period_end = run & ~phase_hi_q & at_end;

    // idle carrier restarts in its high phase at count zero
    p_idle_restart_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0 && phase_hi_q));

endmodule

// File: rtl/cmt_modulator.sv
`timescale 1ns/1ps
module cmt_modulator
    import cmt_pkg::*;
#(
    parameter int MARK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              fsk,
    input  logic              mod_tick,
    input  logic              period_end,
    input  logic [MARK_W-1:0] mark_buf,
    input  logic [MARK_W-1:0] space_buf,
    output logic              running,
    output logic              gate,
    output logic              sel,
    output logic              cyc_end
);

    localparam int CNT_W = MARK_W + 1;

    typedef struct packed {
        logic              running;
        logic              sel;
        logic              cyc;
        logic [CNT_W-1:0]  cnt;
        logic [MARK_W-1:0] spw;
    } mod_state_t;

    mod_state_t       st_q, st_d;
    logic [CNT_W-1:0] nxt;
    logic             tick, hit;

    assign tick = fsk ? period_end : mod_tick;
    assign nxt  = st_q.cnt - CNT_W'(1);
    // negative count whose inverse equals the held space value
    assign hit  = nxt[MARK_W] && (~nxt[MARK_W-1:0] == st_q.spw);

    always_comb begin
        st_d     = st_q;
        st_d.cyc = 1'b0;
        if (!en) begin
            st_d = '0;
        end else if (!st_q.running) begin
            st_d.running = 1'b1;
            st_d.cnt     = {1'b0, mark_buf};
            st_d.spw     = space_buf;
        end else if (tick) begin
            if (hit) begin
                st_d.cnt = {1'b0, mark_buf};
                st_d.spw = space_buf;
                st_d.cyc = 1'b1;
                st_d.sel = st_q.sel ^ fsk;
            end else begin
                st_d.cnt = nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign running = st_q.running;
    assign gate    = ~st_q.cnt[MARK_W];
    assign sel     = st_q.sel;
    assign cyc_end = st_q.cyc;

    // no tick, no count change
    p_hold_without_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q.running && en && !tick) |=> $stable(st_q.cnt));

    // a reload always reopens the gate
    p_reload_opens_gate_r4: assert property (@(posedge clk) disable iff (rst)
        cyc_end |-> gate);

    // setting selection moves only at a carrier period boundary
    p_sel_at_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q.running && en && !period_end) |=> $stable(st_q.sel));

    // disable clears the modulator
    p_cleared_when_off_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st_q.cnt == '0 && st_q.spw == '0 && !st_q.running && !st_q.sel && !cyc_end));

endmodule

// File: rtl/cmt_modulated_tx.sv
`timescale 1ns/1ps
module cmt_modulated_tx
    import cmt_pkg::*;
#(
    parameter int MARK_W = 16,
    parameter int CAR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [MARK_W-1:0] wr_data,
    input  logic              mod_tick,
    output logic              tx_out,
    output logic              cycle_end
);

    logic [NUM_PAIRS-1:0][CAR_W-1:0] hi_cnt, lo_cnt;
    logic [MARK_W-1:0]               mark_buf, space_buf;
    ctrl_t                           ctrl;
    logic                            running, gate, sel, cyc_end;
    logic                            carrier, period_end;

    cmt_regs #(.MARK_W(MARK_W), .CAR_W(CAR_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .hi_cnt    (hi_cnt),
        .lo_cnt    (lo_cnt),
        .mark_buf  (mark_buf),
        .space_buf (space_buf),
        .ctrl      (ctrl)
    );

    cmt_carrier #(.CAR_W(CAR_W)) carrier_i (
        .clk        (clk),
        .rst        (rst),
        .run        (running),
        .sel        (sel),
        .hi_cnt     (hi_cnt),
        .lo_cnt     (lo_cnt),
        .carrier    (carrier),
        .period_end (period_end)
    );

    cmt_modulator #(.MARK_W(MARK_W)) modulator_i (
        .clk        (clk),
        .rst        (rst),
        .en         (ctrl.en),
        .fsk        (mode_is_fsk(ctrl)),
        .mod_tick   (mod_tick),
        .period_end (period_end),
        .mark_buf   (mark_buf),
        .space_buf  (space_buf),
        .running    (running),
        .gate       (gate),
        .sel        (sel),
        .cyc_end    (cyc_end)
    );

    assign tx_out    = ctrl.en & running & gate & (mode_is_base(ctrl) ? 1'b1 : carrier);
    assign cycle_end = ctrl.en & cyc_end;

    // in baseband mode each new mark starts with the output high
    p_mark_start_high_r8: assert property (@(posedge clk) disable iff (rst)
        (cycle_end && ctrl.mode == MODE_BASE) |-> tx_out);

endmodule

// File: tb/cmt_modulated_tx_tb_top.sv
`timescale 1ns/1ps
module cmt_modulated_tx_tb_top;

    localparam int MW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [MW-1:0] wr_data = '0;
    logic          mod_tick = 1'b0;
    logic          tx_out, cycle_end;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    cmt_modulated_tx dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .mod_tick  (mod_tick),
        .tx_out    (tx_out),
        .cycle_end (cycle_end)
    );

    function automatic int nz(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(string req, logic act, logic exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = MW'(d);
        @(posedge clk);
        #1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // program, enable, then compare every cycle with an arithmetic model
    task automatic run(string tag, int mode, int m, int s, int ha, int la, int hb, int lb,
                       int tick_every, int n, int chg_at, int chg_mark);
        int  bm, mm, ss, pos, cc, pair, hl, ll;
        bit  fsk, base, pend, adv, ce, t, w;
        logic exp_tx;
        fsk  = (mode == 2);
        base = (mode == 1);
        wr(6, 0);
        wr(0, ha); wr(1, la); wr(2, hb); wr(3, lb);
        wr(4, m);  wr(5, s);
        wr(6, (mode << 1) | 1);
        chk("R10", tx_out, 1'b0, {tag, " load cycle output"});
        @(posedge clk);
        #1;
        bm = m; mm = m; ss = s; pos = 0; cc = 0; pair = 0;
        for (int c = 0; c < n; c++) begin
            ce = 1'b0;
            if (c > 0) begin
                @(negedge clk);
                t        = (tick_every > 0) && (c % tick_every == 0);
                w        = (c == chg_at);
                mod_tick = t;
                wr_en    = w;
                wr_addr  = 3'd4;
                wr_data  = MW'(chg_mark);
                @(posedge clk);
                #1;
                hl   = nz(pair ? hb : ha);
                ll   = nz(pair ? lb : la);
                cc   = cc + 1;
                pend = 1'b0;
                if (cc == hl + ll) begin cc = 0; pend = 1'b1; end
                adv = fsk ? pend : t;
                if (adv) begin
                    pos = pos + 1;
                    if (pos == mm + 1 + ss) begin
                        pos = 0; mm = bm; ss = s; ce = 1'b1;
                        if (fsk) pair = pair ^ 1;
                    end
                end
                if (w) bm = chg_mark;
            end
            hl = nz(pair ? hb : ha);
            exp_tx = (pos <= mm) && (base || (cc < hl));
            chk(tag, tx_out, exp_tx, $sformatf("tx_out cycle %0d", c));
            chk(tag, cycle_end, ce, $sformatf("cycle_end cycle %0d", c));
        end
        @(negedge clk);
        wr_en    = 1'b0;
        mod_tick = 1'b0;
    endtask

    initial begin
        #750000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R11", tx_out, 1'b0, "reset tx_out");
        chk("R11", cycle_end, 1'b0, "reset cycle_end");

        // R3 R4 R6 R8: baseband sweep of mark and space
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 4; s++)
                run("R3 R4 R6 R8", 1, m, s, 1, 1, 1, 1, 1, 24, -1, 0);

        // R2 R5: time mode over several carrier shapes, including a zero count
        run("R2 R5", 0, 5, 3, 1, 1, 1, 1, 1, 50, -1, 0);
        run("R2 R5", 0, 5, 3, 2, 3, 1, 1, 1, 50, -1, 0);
        run("R2 R5", 0, 4, 0, 3, 1, 1, 1, 1, 50, -1, 0);
        run("R2 R5", 0, 2, 2, 0, 2, 1, 1, 1, 50, -1, 0);

        // R3: sparse ticks stretch the intervals
        run("R3", 1, 2, 1, 1, 1, 1, 1, 3, 60, -1, 0);
        run("R3 R5", 0, 1, 2, 1, 2, 1, 1, 2, 60, -1, 0);

        // R1: reserved mode 11 behaves as time mode
        run("R1 R5", 3, 3, 2, 2, 1, 1, 1, 1, 40, -1, 0);

        // R9: mark buffer changed mid-period applies at next reload
        run("R9", 1, 3, 2, 1, 1, 1, 1, 1, 30, 2, 1);
        run("R9", 1, 1, 1, 1, 1, 1, 1, 1, 30, 1, 4);

        // R7: frequency-shift alternation, mod_tick ignored
        run("R7", 2, 1, 1, 1, 1, 2, 3, 1, 90, -1, 0);
        run("R7", 2, 2, 0, 2, 1, 1, 2, 0, 90, -1, 0);

        // R10: disable holds output low, then restart begins with setting A
        wr(6, 0);
        chk("R10", tx_out, 1'b0, "tx_out after disable write");
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            mod_tick = 1'b1;
            @(posedge clk);
            #1;
            chk("R10", tx_out, 1'b0, "tx_out while disabled");
            chk("R10", cycle_end, 1'b0, "cycle_end while disabled");
        end
        mod_tick = 1'b0;
        run("R7 R10", 2, 0, 1, 1, 2, 3, 1, 0, 60, -1, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule